// File: doc/BRIEF.md
# PCI Hotplug Status Register Bank

This block keeps the hot-add and hot-remove bookkeeping for a parameterised number of hotplug buses. Each bus has 32 slots. Platform logic reports two kinds of event on side inputs: a device that has arrived (a plug event) and a request to remove a device (an unplug request). Each event names a bus and a slot. The block records the event in a per-bus arrival mask or departure mask and pulses an interrupt line toward the event controller.

Firmware reaches the bank through a small 32-bit register window. It first picks a bus with the select register. It then reads the arrival, departure and removable masks of that bus. It acknowledges a removal by writing to the eject register. An accepted eject produces a one-cycle pulse that carries the bus and slot to whatever performs the device teardown. A legacy-mode input changes two behaviours: reading the arrival mask no longer clears it, and the select register is pinned to bus 0.

A sweep sequencer starts after every reset and whenever `rescan` is pulsed. It visits the buses in ascending order. On each bus it first ejects the pending departure bits one at a time, then reloads the removable mask from the per-bus fixed-device input. The sequencer has three states:
- `ST_DRAIN` ejects the lowest pending departure bit of the current bus each cycle. It moves to `ST_LOAD` when that bus has no departure bits left.
- `ST_LOAD` loads the removable mask of the current bus. It then goes back to `ST_DRAIN` for the next bus, or moves to `ST_IDLE` after the last bus.
- `ST_IDLE` waits for `rescan` and then moves to `ST_DRAIN` at bus 0.

Reset enters `ST_DRAIN` at bus 0.

Top module: `hp_status_regs`

## Requirements
- R1: Registers sit at byte offsets 0x00 (arrival mask), 0x04 (departure mask), 0x08 (eject), 0x0C (removable mask) and 0x10 (bus select). Slot n is bit n. An access whose address has bits [1:0] not equal to 00, or whose offset is unused, reads 0 and changes nothing.
- R2: An accepted plug event sets bit `plug_slot` in the arrival mask of `plug_bus`. An accepted unplug request sets bit `unplug_slot` in the departure mask of `unplug_bus`. An event that names a bus index of NUM_BUS or above is ignored.
- R3: `hp_event` is high for exactly one cycle, in the cycle after any cycle with at least one accepted plug or unplug event. A plug and an unplug in the same cycle are both recorded and give a single pulse.
- R4: Reading the arrival mask returns the selected bus's bits. Outside legacy mode the read also clears them; in legacy mode they are kept. A plug arriving in the same cycle as a clearing read survives.
- R5: Reading the departure mask or the removable mask returns the selected bus's value. Reading the eject offset returns 0. Reading the select offset returns the stored select value.
- R6: Outside legacy mode, a write to the select offset stores the written word. In legacy mode it stores 0.
- R7: While the select value is NUM_BUS or above, every read returns 0 and eject writes are ignored.
- R8: An eject write with nonzero data acts on the slot given by the lowest set bit of the data, on the selected bus. It clears that slot's arrival and departure bits. In the next cycle it pulses `eject_pulse` with `eject_bus` and `eject_slot` set to that bus and slot. An eject write of 0 does nothing.
- R9: An eject aimed at a slot whose removable bit is 0 still clears the slot's arrival and departure bits, but produces no pulse.
- R10: After reset and after a `rescan` pulse, the sequencer ejects every pending departure bit. It goes bus by bus in ascending order and, within a bus, slot by slot in ascending order, with the R9 rule applied. It sets each bus's removable mask to the inverse of that bus's 32-bit field of `fixed_mask`. Register accesses are ignored while the sweep runs.
- R11: `reg_rdata` carries the read result in the cycle after `reg_rd` and is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Keeps the arrival mask on read and pins select to 0 |
| rescan | input | 1 | Starts a sweep when the sequencer is idle |
| plug_vld | input | 1 | Plug event valid |
| plug_bus | input | BUS_IN_W | Bus of the plug event |
| plug_slot | input | 5 | Slot of the plug event |
| unplug_vld | input | 1 | Unplug request valid |
| unplug_bus | input | BUS_IN_W | Bus of the unplug request |
| unplug_slot | input | 5 | Slot of the unplug request |
| fixed_mask | input | NUM_BUS*32 | Per bus, 32 bits marking slots that hold fixed devices |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset in the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| eject_pulse | output | 1 | One-cycle eject command |
| eject_bus | output | BUS_IN_W | Bus of the eject command |
| eject_slot | output | 5 | Slot of the eject command |
| hp_event | output | 1 | One-cycle hotplug event pulse |

## Verification
The assertions assume that `reg_rd` is low while reset is held. This lets the one-cycle look-back on the read path start from a known state. The bench never raises the read and write strobes in the same cycle. Its random bus indices reach past NUM_BUS on purpose, so the ignore rule is exercised against the event-pulse property. Random register traffic is issued only after the reset sweep has finished; the sweep is tested on its own, using a directed `rescan` with no other traffic.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int SLOT_N = 32;
    localparam int SLOT_W = 5;

    localparam logic [4:0] OFS_UP  = 5'h00;
    localparam logic [4:0] OFS_DN  = 5'h04;
    localparam logic [4:0] OFS_EJ  = 5'h08;
    localparam logic [4:0] OFS_RMV = 5'h0C;
    localparam logic [4:0] OFS_SEL = 5'h10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_LOAD  = 2'd2
    } sweep_st_t;

    // index of the lowest set bit; 0 for an empty mask
    function automatic logic [SLOT_W-1:0] lowest_set(input logic [SLOT_N-1:0] m);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = SLOT_N - 1; i >= 0; i--) begin
            if (m[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_N-1:0] set_up,
    input  logic [SLOT_N-1:0] set_dn,
    input  logic [SLOT_N-1:0] clr_slot,
    input  logic              clr_up_all,
    input  logic              load_rmv,
    input  logic [SLOT_N-1:0] rmv_val,
    output logic [SLOT_N-1:0] up_q,
    output logic [SLOT_N-1:0] dn_q,
    output logic [SLOT_N-1:0] rmv_q
);

    logic [SLOT_N-1:0] up_keep;

    always_comb begin
        up_keep = up_q & ~clr_slot;
        if (clr_up_all) up_keep = '0;
    end

    // new events take priority over any clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q  <= '0;
            dn_q  <= '0;
            rmv_q <= '1;
        end else begin
            up_q <= up_keep | set_up;
            dn_q <= (dn_q & ~clr_slot) | set_dn;
            if (load_rmv) rmv_q <= rmv_val;
        end
    end

endmodule

// File: rtl/hp_sweep_ctrl.sv
module hp_sweep_ctrl
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rescan,
    input  logic [SLOT_N-1:0] cur_down,
    output logic [IDX_W-1:0]  cur_bus,
    output logic              busy,
    output logic              drain_go,
    output logic              load_go
);

    localparam logic [IDX_W-1:0] LAST_BUS = IDX_W'(NUM_BUS - 1);

    sweep_st_t        state_q, state_d;
    logic [IDX_W-1:0] bus_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DRAIN;
            cur_bus <= '0;
        end else begin
            state_q <= state_d;
            cur_bus <= bus_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bus_d   = cur_bus;
        unique case (state_q)
            ST_IDLE: begin
                if (rescan) begin
                    state_d = ST_DRAIN;
                    bus_d   = '0;
                end
            end
            ST_DRAIN: begin
                if (cur_down == '0) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (cur_bus == LAST_BUS) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_DRAIN;
                    bus_d   = cur_bus + IDX_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b1;
        drain_go = 1'b0;
        load_go  = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_DRAIN: drain_go = (cur_down != '0);
            ST_LOAD:  load_go = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/hp_status_regs.sv
module hp_status_regs
    import hp_pkg::*;
#(
    parameter int NUM_BUS  = 4,
    parameter int BUS_IN_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    legacy_mode,
    input  logic                    rescan,
    input  logic                    plug_vld,
    input  logic [BUS_IN_W-1:0]     plug_bus,
    input  logic [4:0]              plug_slot,
    input  logic                    unplug_vld,
    input  logic [BUS_IN_W-1:0]     unplug_bus,
    input  logic [4:0]              unplug_slot,
    input  logic [NUM_BUS*32-1:0]   fixed_mask,
    input  logic                    reg_rd,
    input  logic                    reg_wr,
    input  logic [4:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    eject_pulse,
    output logic [BUS_IN_W-1:0]     eject_bus,
    output logic [4:0]              eject_slot,
    output logic                    hp_event
);

    localparam int IDX_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    logic [SLOT_N-1:0] up_a  [NUM_BUS];
    logic [SLOT_N-1:0] dn_a  [NUM_BUS];
    logic [SLOT_N-1:0] rmv_a [NUM_BUS];

    logic [31:0]       sel_q;
    logic              sel_ok;
    logic [IDX_W-1:0]  sel_idx;
    logic              plug_ok, unplug_ok;
    logic              acc_en, rd_up, ej_wr, sel_wr;
    logic [IDX_W-1:0]  cur_bus;
    logic              busy, drain_go, load_go;
    logic [SLOT_N-1:0] cur_down;
    logic              ej_do;
    logic [IDX_W-1:0]  ej_bus_c;
    logic [SLOT_W-1:0] ej_slot_c;
    logic [31:0]       rdata_c;

    assign sel_ok    = (sel_q < 32'(NUM_BUS));
    assign sel_idx   = sel_q[IDX_W-1:0];
    assign plug_ok   = plug_vld && (32'(plug_bus) < 32'(NUM_BUS));
    assign unplug_ok = unplug_vld && (32'(unplug_bus) < 32'(NUM_BUS));

    assign acc_en = !busy && (reg_addr[1:0] == 2'b00);
    assign rd_up  = reg_rd && acc_en && sel_ok && (reg_addr == OFS_UP);
    assign ej_wr  = reg_wr && acc_en && sel_ok && (reg_addr == OFS_EJ) && (reg_wdata != '0);
    assign sel_wr = reg_wr && acc_en && (reg_addr == OFS_SEL);

    assign cur_down = dn_a[cur_bus];

    hp_sweep_ctrl #(
        .NUM_BUS (NUM_BUS),
        .IDX_W   (IDX_W)
    ) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .rescan   (rescan),
        .cur_down (cur_down),
        .cur_bus  (cur_bus),
        .busy     (busy),
        .drain_go (drain_go),
        .load_go  (load_go)
    );

    // the sweep owns the eject path while it runs
    always_comb begin
        ej_do = drain_go || ej_wr;
        if (drain_go) begin
            ej_bus_c  = cur_bus;
            ej_slot_c = lowest_set(cur_down);
        end else begin
            ej_bus_c  = sel_idx;
            ej_slot_c = lowest_set(reg_wdata);
        end
    end

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        logic [SLOT_N-1:0] set_up, set_dn, clr_slot;
        logic              clr_up_all, load_rmv;

        assign set_up     = (plug_ok && (32'(plug_bus) == b)) ? (SLOT_N'(1) << plug_slot) : '0;
        assign set_dn     = (unplug_ok && (32'(unplug_bus) == b)) ? (SLOT_N'(1) << unplug_slot) : '0;
        assign clr_slot   = (ej_do && (32'(ej_bus_c) == b)) ? (SLOT_N'(1) << ej_slot_c) : '0;
        assign clr_up_all = rd_up && !legacy_mode && (32'(sel_idx) == b);
        assign load_rmv   = load_go && (32'(cur_bus) == b);

        hp_slot_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_up     (set_up),
            .set_dn     (set_dn),
            .clr_slot   (clr_slot),
            .clr_up_all (clr_up_all),
            .load_rmv   (load_rmv),
            .rmv_val    (~fixed_mask[b*SLOT_N +: SLOT_N]),
            .up_q       (up_a[b]),
            .dn_q       (dn_a[b]),
            .rmv_q      (rmv_a[b])
        );
    end

    always_comb begin
        rdata_c = '0;
        if (reg_rd && acc_en && sel_ok) begin
            unique case (reg_addr)
                OFS_UP:  rdata_c = up_a[sel_idx];
                OFS_DN:  rdata_c = dn_a[sel_idx];
                OFS_RMV: rdata_c = rmv_a[sel_idx];
                OFS_SEL: rdata_c = sel_q;
                default: rdata_c = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q       <= '0;
            reg_rdata   <= '0;
            eject_pulse <= 1'b0;
            eject_bus   <= '0;
            eject_slot  <= '0;
            hp_event    <= 1'b0;
        end else begin
            if (sel_wr) sel_q <= legacy_mode ? 32'd0 : reg_wdata;
            reg_rdata   <= rdata_c;
            eject_pulse <= ej_do && rmv_a[ej_bus_c][ej_slot_c];
            eject_bus   <= BUS_IN_W'(ej_bus_c);
            eject_slot  <= ej_slot_c;
            hp_event    <= plug_ok || unplug_ok;
        end
    end

endmodule

// File: rtl/hp_status_regs_chk.sv
module hp_status_regs_chk #(
    parameter int NUM_BUS  = 4,
    parameter int BUS_IN_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                plug_vld,
    input logic [BUS_IN_W-1:0] plug_bus,
    input logic                unplug_vld,
    input logic [BUS_IN_W-1:0] unplug_bus,
    input logic                reg_rd,
    input logic [4:0]          reg_addr,
    input logic [31:0]         reg_rdata,
    input logic                eject_pulse,
    input logic [BUS_IN_W-1:0] eject_bus,
    input logic                hp_event
);

    assert_event_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hp_event == $past((plug_vld && (32'(plug_bus) < 32'(NUM_BUS))) ||
                          (unplug_vld && (32'(unplug_bus) < 32'(NUM_BUS)))));

    assert_rdata_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd) |-> reg_rdata == 32'd0);

    assert_misaligned_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && (reg_addr[1:0] != 2'b00)) |-> reg_rdata == 32'd0);

    assert_eject_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && (reg_addr == 5'h08)) |-> reg_rdata == 32'd0);

    assert_eject_bus_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eject_pulse |-> (32'(eject_bus) < 32'(NUM_BUS)));

endmodule

bind hp_status_regs hp_status_regs_chk #(
    .NUM_BUS  (NUM_BUS),
    .BUS_IN_W (BUS_IN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .plug_vld    (plug_vld),
    .plug_bus    (plug_bus),
    .unplug_vld  (unplug_vld),
    .unplug_bus  (unplug_bus),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .eject_pulse (eject_pulse),
    .eject_bus   (eject_bus),
    .hp_event    (hp_event)
);

// File: tb/hp_status_regs_bench.sv
module hp_status_regs_bench;

    localparam int NB = 4;
    localparam int BW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            legacy_mode = 1'b0;
    logic            rescan = 1'b0;
    logic            plug_vld = 1'b0;
    logic [BW-1:0]   plug_bus = '0;
    logic [4:0]      plug_slot = '0;
    logic            unplug_vld = 1'b0;
    logic [BW-1:0]   unplug_bus = '0;
    logic [4:0]      unplug_slot = '0;
    logic [NB*32-1:0] fixed_mask;
    logic            reg_rd = 1'b0;
    logic            reg_wr = 1'b0;
    logic [4:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            eject_pulse;
    logic [BW-1:0]   eject_bus;
    logic [4:0]      eject_slot;
    logic            hp_event;

    always #4 clk = ~clk;

    hp_status_regs #(.NUM_BUS(NB), .BUS_IN_W(BW)) u_hp_status_regs (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .rescan(rescan),
        .plug_vld(plug_vld), .plug_bus(plug_bus), .plug_slot(plug_slot),
        .unplug_vld(unplug_vld), .unplug_bus(unplug_bus), .unplug_slot(unplug_slot),
        .fixed_mask(fixed_mask), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eject_pulse(eject_pulse), .eject_bus(eject_bus), .eject_slot(eject_slot),
        .hp_event(hp_event)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] up_m [NB];
    logic [31:0] dn_m [NB];
    logic [31:0] rmv_m [NB];
    logic [31:0] sel_m = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] low_bit(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return 5'(i);
        return 5'd0;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        if (a[1:0] != 2'b00 || sel_m >= NB) return 32'd0;
        case (a)
            5'h00: return up_m[sel_m[1:0]];
            5'h04: return dn_m[sel_m[1:0]];
            5'h0C: return rmv_m[sel_m[1:0]];
            5'h10: return sel_m;
            default: return 32'd0;
        endcase
    endfunction

    task automatic do_read(input logic [4:0] a, input string req);
        logic [31:0] e;
        e = exp_rd(a);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rdata == e, req, reg_rdata, e);
        if (a == 5'h00 && sel_m < NB && !legacy_mode) up_m[sel_m[1:0]] = 32'd0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d, input string req);
        bit ep; logic [4:0] s; logic [1:0] b;
        ep = 1'b0; s = low_bit(d); b = sel_m[1:0];
        if (a == 5'h08 && sel_m < NB && d != 0) begin
            ep = rmv_m[b][s];
            up_m[b][s] = 1'b0;
            dn_m[b][s] = 1'b0;
        end
        if (a == 5'h10) sel_m = legacy_mode ? 32'd0 : d;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        check(eject_pulse == ep, req, 32'(eject_pulse), 32'(ep));
        if (ep) check({eject_bus, eject_slot} == {BW'(b), s}, req, 32'({eject_bus, eject_slot}), 32'({BW'(b), s}));
    endtask

    task automatic do_event(input bit pv, input int pb, input int ps, input bit uv, input int ub, input int us, input string req);
        bit ev;
        ev = (pv && pb < NB) || (uv && ub < NB);
        if (pv && pb < NB) up_m[pb][ps] = 1'b1;
        if (uv && ub < NB) dn_m[ub][us] = 1'b1;
        plug_vld = pv; plug_bus = BW'(pb); plug_slot = 5'(ps);
        unplug_vld = uv; unplug_bus = BW'(ub); unplug_slot = 5'(us);
        @(negedge clk);
        plug_vld = 1'b0; unplug_vld = 1'b0;
        check(hp_event == ev, req, 32'(hp_event), 32'(ev));
    endtask

    initial begin
        fixed_mask = '0;
        fixed_mask[1*32 + 3]  = 1'b1;
        fixed_mask[2*32 + 31] = 1'b1;
        for (int b = 0; b < NB; b++) begin
            up_m[b] = 0; dn_m[b] = 0; rmv_m[b] = ~fixed_mask[b*32 +: 32];
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // reset state and idle read data
        check(reg_rdata == 0, "R11 idle rdata", reg_rdata, 0);
        check(hp_event == 0 && eject_pulse == 0, "R3 reset outputs", 32'({hp_event, eject_pulse}), 0);
        do_read(5'h00, "R4 reset arrival");
        do_read(5'h10, "R5 reset select");
        do_write(5'h10, 32'd1, "R6 select bus1");
        do_read(5'h0C, "R10 removable after reset");
        do_read(5'h08, "R5 eject reads zero");

        // R4 clear on read outside legacy
        do_event(1, 1, 7, 0, 0, 0, "R2 plug bus1");
        do_read(5'h00, "R4 arrival read");
        do_read(5'h00, "R4 arrival cleared");

        // R4 plug racing a clearing read
        do_event(1, 1, 12, 0, 0, 0, "R2 plug bus1 s12");
        begin
            logic [31:0] e;
            e = up_m[1];
            reg_rd = 1; reg_addr = 5'h00;
            plug_vld = 1; plug_bus = 1; plug_slot = 20;
            @(negedge clk);
            reg_rd = 0; plug_vld = 0;
            check(reg_rdata == e, "R4 race read", reg_rdata, e);
            check(hp_event == 1, "R3 race event", 32'(hp_event), 1);
            up_m[1] = 32'h1 << 20;
            do_read(5'h00, "R4 race plug survives");
        end

        // R3 simultaneous events, R2 out-of-range bus
        do_event(1, 2, 4, 1, 2, 9, "R3 dual event");
        do_event(1, 5, 1, 1, 9, 2, "R2 out of range ignored");
        do_write(5'h10, 32'd2, "R6 select bus2");
        do_read(5'h00, "R2 bus2 arrival");
        do_read(5'h04, "R2 bus2 departure");

        // R8 eject by lowest set bit
        do_event(0, 0, 0, 1, 2, 9, "R2 unplug bus2 s9");
        do_write(5'h08, 32'h0000_0A00, "R8 eject lowest bit");
        do_read(5'h04, "R8 departure cleared");
        do_write(5'h08, 32'd0, "R8 eject zero ignored");

        // R9 fixed slot
        do_write(5'h10, 32'd1, "R6 select bus1");
        do_event(1, 1, 3, 1, 1, 3, "R2 fixed slot events");
        do_write(5'h08, 32'h8, "R9 no pulse fixed slot");
        do_read(5'h00, "R9 arrival cleared");
        do_read(5'h04, "R9 departure cleared");

        // R1 misaligned and unused offsets
        do_read(5'h02, "R1 misaligned read");
        do_read(5'h14, "R1 unused offset read");
        do_write(5'h11, 32'd3, "R1 misaligned write ignored");
        do_read(5'h10, "R1 select unchanged");

        // R7 out-of-range select
        do_write(5'h10, 32'd7, "R6 select 7");
        do_read(5'h10, "R7 select read zero");
        do_read(5'h0C, "R7 removable read zero");
        do_write(5'h08, 32'h1, "R7 eject ignored");

        // R6 and R4 in legacy mode
        legacy_mode = 1;
        do_write(5'h10, 32'd3, "R6 legacy select");
        do_read(5'h10, "R6 legacy select reads 0");
        do_event(1, 0, 2, 0, 0, 0, "R2 plug bus0");
        do_read(5'h00, "R4 legacy read keeps");
        do_read(5'h00, "R4 legacy second read");
        legacy_mode = 0;
        do_read(5'h00, "R4 non-legacy clears");

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: do_event($urandom % 2, $urandom % 6, $urandom % 32,
                            $urandom % 2, $urandom % 6, $urandom % 32, "R3 random event");
                1: begin
                    logic [4:0] a;
                    a = 5'(($urandom % 6) * 4);
                    if ($urandom % 8 == 0) a = 5'(a | 5'h1);
                    do_read(a, "R5 random read");
                end
                2: do_write(5'h10, ($urandom % 8 == 0) ? 32'd5 : $urandom % NB, "R6 random select");
                default: do_write(5'h08, $urandom & $urandom & $urandom, "R8 random eject");
            endcase
        end

        // R10 sweep on rescan
        for (int b = 0; b < NB; b++) begin
            sel_m = b; do_write(5'h10, b, "R6 select for clear");
            do_read(5'h00, "R4 drain arrival");
            while (dn_m[b] != 0) do_write(5'h08, dn_m[b], "R8 drain departure");
        end
        do_event(0, 0, 0, 1, 0, 9, "R2 sweep setup");
        do_event(1, 0, 5, 1, 0, 5, "R2 sweep setup");
        do_event(0, 0, 0, 1, 2, 31, "R2 sweep setup");
        do_event(0, 0, 0, 1, 3, 0, "R2 sweep setup");
        rescan = 1;
        @(negedge clk);
        rescan = 0;
        begin
            int n;
            logic [8:0] got [8];
            n = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (eject_pulse && n < 8) begin
                    got[n] = {eject_bus, eject_slot};
                    n++;
                end
            end
            check(n == 3, "R10 sweep pulse count", n, 3);
            if (n == 3) begin
                check(got[0] == {4'd0, 5'd5}, "R10 sweep order 0", 32'(got[0]), 32'({4'd0, 5'd5}));
                check(got[1] == {4'd0, 5'd9}, "R10 sweep order 1", 32'(got[1]), 32'({4'd0, 5'd9}));
                check(got[2] == {4'd3, 5'd0}, "R10 sweep order 2", 32'(got[2]), 32'({4'd3, 5'd0}));
            end
        end
        up_m[0][5] = 0; dn_m[0] = 0; dn_m[2] = 0; dn_m[3] = 0;
        do_write(5'h10, 32'd0, "R6 select bus0");
        do_read(5'h00, "R10 arrival cleared by sweep");
        do_read(5'h04, "R10 departure cleared by sweep");
        do_write(5'h10, 32'd2, "R6 select bus2");
        do_read(5'h04, "R10 fixed slot departure cleared");
        do_read(5'h0C, "R10 removable reloaded");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule